// File: doc/BRIEF.md
# Four-Pixel Sum-of-Absolute-Differences Engine

This block measures how far one line of four current-block pixels lies from four reference pixels. A start pulse captures a current-block start address, a reference start address, a reference stride, a reference-memory selector and a destination register index. The engine then fetches one byte per cycle from the current-block memory and, in the same cycles, one byte from the selected reference memory. It forms the absolute difference of each pair, adds the four differences, and writes the sum into a general-purpose register through a one-cycle write port.

The same engine serves integer-position and half-position searches. Only the stride and the reference memory change between them. On the half-position grid the stride is normally 2. Software builds larger partition costs by issuing one call per four-pixel line and adding the results, so a 4x4 block takes four calls, and software may leave out lines to save work. The latency is fixed at nine cycles whatever the operands.

The controller is a four-state machine. IDLE waits for a start. FETCH issues the four paired reads. FLUSH lets the difference and accumulate pipeline empty and pads the operation to its fixed latency. REPORT drives the write port and the done pulse for one cycle. The transitions are as follows. IDLE goes to FETCH when start is seen. FETCH goes to FLUSH after its fourth read. FLUSH goes to REPORT after its fourth cycle. REPORT always returns to IDLE.

Top module: `sad4_engine`

## Requirements
- R1: The written value is the sum of |cur[i] - ref[i]| over the four fetched pixel pairs (unsigned 8-bit pixels). Its range is 0 to 1020.
- R2: A start is accepted at a rising clock edge where start is high and busy is low. done and gpr_we are then high for exactly one cycle, the ninth cycle after that edge, counting the cycle that follows the edge as the first.
- R3: The current-block reads go to addresses cur_base, cur_base+1, cur_base+2 and cur_base+3, modulo 2^AW. They are issued one per cycle with cur_rd_en high, in cycles 1 to 4 after the accepting edge.
- R4: In the same four cycles the reference reads go to ref_base + k*stride for k = 0..3, modulo 2^AW. Each memory returns its data one cycle after the read.
- R5: With ref_sel = 0 only the integer-position memory is read (full_rd_en). With ref_sel = 1 only the half-position memory is read (half_rd_en). The enable of the unselected memory stays low for the whole operation.
- R6: gpr_waddr equals the dest value captured at the accepting edge. gpr_wdata carries the 10-bit sum zero-extended to 16 bits, so bits 15..10 are 0.
- R7: busy is high from the cycle after the accepting edge through the done cycle, and low otherwise. A start seen while busy is high has no effect: no extra done, and no change to the result or the destination.
- R8: While reset is asserted, and right after it, busy, done, gpr_we and all three read enables are low.
- R9: cur_base, ref_base, stride, ref_sel and dest are sampled only at the accepting edge. Changing them later does not change the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch request |
| dest | input | 4 | Destination register index |
| cur_base | input | AW | First current-block address |
| ref_base | input | AW | First reference address |
| stride | input | AW | Reference address step |
| ref_sel | input | 1 | 0 integer-position memory, 1 half-position memory |
| cur_rd_en | output | 1 | Current-block memory read enable |
| cur_rd_addr | output | AW | Current-block memory address |
| cur_rd_data | input | 8 | Current-block memory data, one cycle after read |
| full_rd_en | output | 1 | Integer-position memory read enable |
| half_rd_en | output | 1 | Half-position memory read enable |
| ref_rd_addr | output | AW | Address shared by both reference memories |
| full_rd_data | input | 8 | Integer-position memory data |
| half_rd_data | input | 8 | Half-position memory data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result-ready pulse |
| gpr_we | output | 1 | Register write strobe |
| gpr_waddr | output | 4 | Register write index |
| gpr_wdata | output | 16 | Register write data |

## Verification
A new start can fall in the same cycle as an operation that is still fetching, or in the same cycle as the done pulse of the previous operation. Both cases should be ignored. The bench raises start with different operands in the second cycle of a fetch, and separately in the REPORT cycle. It then checks that exactly one done appears in the window and that the written index and sum still belong to the first operation. It also launches a new operation in the cycle right after done and checks that this start is accepted with the full nine-cycle latency.

// File: rtl/sad4_pkg.sv
package sad4_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_FLUSH,
        ST_REPORT
    } sad4_state_e;

    function automatic int unsigned sum_width(input int unsigned pix_w, input int unsigned npix);
        return pix_w + $clog2(npix);
    endfunction

endpackage

// File: rtl/sad4_ctrl.sv
module sad4_ctrl
    import sad4_pkg::*;
#(
    parameter int NPIX    = 4,
    parameter int LATENCY = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic issue,
    output logic report,
    output logic busy
);
    localparam int FLUSH_CYC = LATENCY - 1 - NPIX;
    localparam int CW        = $clog2(NPIX + FLUSH_CYC + 1);

    sad4_state_e   state_q, state_d;
    logic [CW-1:0] beat_q, beat_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            ST_IDLE: begin
                beat_d = '0;
                if (start) state_d = ST_FETCH;
            end
            ST_FETCH: begin
                if (beat_q == CW'(NPIX - 1)) begin
                    state_d = ST_FLUSH;
                    beat_d  = '0;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_FLUSH: begin
                if (beat_q == CW'(FLUSH_CYC - 1)) begin
                    state_d = ST_REPORT;
                    beat_d  = '0;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_REPORT: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
            default: begin
                state_d = ST_IDLE;
                beat_d  = '0;
            end
        endcase
    end

    always_comb begin
        accept = 1'b0;
        issue  = 1'b0;
        report = 1'b0;
        busy   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_FETCH:  issue  = 1'b1;
            ST_FLUSH:  issue  = 1'b0;
            ST_REPORT: report = 1'b1;
            default:   busy   = 1'b0;
        endcase
    end

endmodule

// File: rtl/sad4_addr_gen.sv
module sad4_addr_gen #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          issue,
    input  logic [AW-1:0] cur_base,
    input  logic [AW-1:0] ref_base,
    input  logic [AW-1:0] stride,
    input  logic          ref_sel,
    output logic [AW-1:0] cur_addr,
    output logic [AW-1:0] ref_addr,
    output logic          cur_en,
    output logic          full_en,
    output logic          half_en,
    output logic          sel_q
);
    logic [AW-1:0] cur_ptr_q, ref_ptr_q, stride_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr_q <= '0;
            ref_ptr_q <= '0;
            stride_q  <= '0;
            sel_q     <= 1'b0;
        end else if (accept) begin
            cur_ptr_q <= cur_base;
            ref_ptr_q <= ref_base;
            stride_q  <= stride;
            sel_q     <= ref_sel;
        end else if (issue) begin
            cur_ptr_q <= cur_ptr_q + 1'b1;
            ref_ptr_q <= ref_ptr_q + stride_q;
        end
    end

    always_comb begin
        cur_addr = cur_ptr_q;
        ref_addr = ref_ptr_q;
        cur_en   = issue;
        full_en  = issue & ~sel_q;
        half_en  = issue & sel_q;
    end

endmodule

// File: rtl/sad4_absacc.sv
module sad4_absacc #(
    parameter int DW    = 8,
    parameter int SUM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             issue,
    input  logic             sel_q,
    input  logic [DW-1:0]    cur_data,
    input  logic [DW-1:0]    full_data,
    input  logic [DW-1:0]    half_data,
    output logic [SUM_W-1:0] sum
);
    logic          data_v_q, diff_v_q;
    logic [DW-1:0] ref_pix, diff_d, diff_q;
    logic [SUM_W-1:0] acc_q;

    always_comb begin
        ref_pix = sel_q ? half_data : full_data;
        diff_d  = (cur_data >= ref_pix) ? (cur_data - ref_pix) : (ref_pix - cur_data);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_v_q <= 1'b0;
            diff_v_q <= 1'b0;
            diff_q   <= '0;
            acc_q    <= '0;
        end else begin
            data_v_q <= issue;
            diff_v_q <= data_v_q;
            if (data_v_q) diff_q <= diff_d;
            if (clear)         acc_q <= '0;
            else if (diff_v_q) acc_q <= acc_q + SUM_W'(diff_q);
        end
    end

    assign sum = acc_q;

endmodule

// File: rtl/sad4_engine.sv
module sad4_engine
    import sad4_pkg::*;
#(
    parameter int AW      = 10,
    parameter int DW      = 8,
    parameter int NPIX    = 4,
    parameter int LATENCY = 9,
    parameter int RA_W    = 4,
    parameter int RES_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RA_W-1:0]  dest,
    input  logic [AW-1:0]    cur_base,
    input  logic [AW-1:0]    ref_base,
    input  logic [AW-1:0]    stride,
    input  logic             ref_sel,
    output logic             cur_rd_en,
    output logic [AW-1:0]    cur_rd_addr,
    input  logic [DW-1:0]    cur_rd_data,
    output logic             full_rd_en,
    output logic             half_rd_en,
    output logic [AW-1:0]    ref_rd_addr,
    input  logic [DW-1:0]    full_rd_data,
    input  logic [DW-1:0]    half_rd_data,
    output logic             busy,
    output logic             done,
    output logic             gpr_we,
    output logic [RA_W-1:0]  gpr_waddr,
    output logic [RES_W-1:0] gpr_wdata
);
    localparam int SUM_W = sum_width(DW, NPIX);

    logic accept, issue, report, sel_q;
    logic [SUM_W-1:0] sum;
    logic [RA_W-1:0]  dest_q;

    sad4_ctrl #(.NPIX(NPIX), .LATENCY(LATENCY)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .issue(issue), .report(report), .busy(busy)
    );

    sad4_addr_gen #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .accept(accept), .issue(issue),
        .cur_base(cur_base), .ref_base(ref_base), .stride(stride), .ref_sel(ref_sel),
        .cur_addr(cur_rd_addr), .ref_addr(ref_rd_addr),
        .cur_en(cur_rd_en), .full_en(full_rd_en), .half_en(half_rd_en), .sel_q(sel_q)
    );

    sad4_absacc #(.DW(DW), .SUM_W(SUM_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(accept), .issue(issue), .sel_q(sel_q),
        .cur_data(cur_rd_data), .full_data(full_rd_data), .half_data(half_rd_data),
        .sum(sum)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)      dest_q <= '0;
        else if (accept) dest_q <= dest;
    end

    generate
        if (RES_W > SUM_W) begin : g_zext
            assign gpr_wdata = {{(RES_W - SUM_W){1'b0}}, sum};
        end else begin : g_trunc
            assign gpr_wdata = sum[RES_W-1:0];
        end
    endgenerate

    assign gpr_we    = report;
    assign done      = report;
    assign gpr_waddr = dest_q;

endmodule

// File: rtl/sad4_engine_chk.sv
module sad4_engine_chk #(
    parameter int RES_W = 16,
    parameter int SUM_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             gpr_we,
    input logic [RES_W-1:0] gpr_wdata,
    input logic             cur_rd_en,
    input logic             full_rd_en,
    input logic             half_rd_en
);
    logic [3:0] since_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= '0;
        else if (start && !busy)   since_q <= 4'd1;
        else if (since_q == 4'd9)  since_q <= '0;
        else if (since_q != 4'd0)  since_q <= since_q + 1'b1;
    end

    // R2
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q == 4'd9) |-> (done && gpr_we));

    // R2
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since_q == 4'd9));

    // R7
    busy_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_q != 4'd0) |-> busy);

    // R7
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R5
    ref_mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_rd_en && half_rd_en));

    // R3
    paired_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_rd_en |-> (busy && (full_rd_en || half_rd_en)));

    // R6
    zero_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (gpr_wdata[RES_W-1:SUM_W] == '0));

endmodule

bind sad4_engine sad4_engine_chk #(.RES_W(RES_W), .SUM_W(SUM_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .gpr_we(gpr_we), .gpr_wdata(gpr_wdata), .cur_rd_en(cur_rd_en),
    .full_rd_en(full_rd_en), .half_rd_en(half_rd_en)
);

// File: tb/tb_sad4_engine.sv
`timescale 1ns/1ps
module tb_sad4_engine;
    localparam int AW = 10;
    localparam int M  = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [3:0] dest = '0;
    logic [AW-1:0] cur_base = '0, ref_base = '0, stride = '0;
    logic ref_sel = 1'b0;
    logic cur_rd_en, full_rd_en, half_rd_en;
    logic [AW-1:0] cur_rd_addr, ref_rd_addr;
    logic [7:0] cur_rd_data, full_rd_data, half_rd_data;
    logic busy, done, gpr_we;
    logic [3:0] gpr_waddr;
    logic [15:0] gpr_wdata;

    logic [7:0] cur_mem [M];
    logic [7:0] full_mem [M];
    logic [7:0] half_mem [M];

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sad4_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dest(dest),
        .cur_base(cur_base), .ref_base(ref_base), .stride(stride), .ref_sel(ref_sel),
        .cur_rd_en(cur_rd_en), .cur_rd_addr(cur_rd_addr), .cur_rd_data(cur_rd_data),
        .full_rd_en(full_rd_en), .half_rd_en(half_rd_en), .ref_rd_addr(ref_rd_addr),
        .full_rd_data(full_rd_data), .half_rd_data(half_rd_data),
        .busy(busy), .done(done), .gpr_we(gpr_we), .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata)
    );

    always @(posedge clk) begin
        if (cur_rd_en)  cur_rd_data  <= cur_mem[cur_rd_addr];
        if (full_rd_en) full_rd_data <= full_mem[ref_rd_addr];
        if (half_rd_en) half_rd_data <= half_mem[ref_rd_addr];
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_sad(input int cb, input int rb, input int st, input bit hs);
        int s = 0;
        for (int i = 0; i < 4; i++) begin
            int c = cur_mem[(cb + i) % M];
            int r = hs ? half_mem[(rb + i * st) % M] : full_mem[(rb + i * st) % M];
            s += (c >= r) ? c - r : r - c;
        end
        return s;
    endfunction

    // inj: cycle index at which a competing start is raised (0 = none)
    task automatic run_op(input int cb, input int rb, input int st, input bit hs,
                          input int dst, input int inj);
        int expv = exp_sad(cb, rb, st, hs);
        int done_k = 0, done_n = 0, cur_n = 0, sel_n = 0, oth_n = 0;
        int wd = 0, wa = 0;
        @(negedge clk);
        start = 1'b1; dest = 4'(dst); cur_base = AW'(cb); ref_base = AW'(rb);
        stride = AW'(st); ref_sel = hs;
        for (int k = 1; k <= 14; k++) begin
            @(negedge clk);
            if (k == 1) begin
                start = 1'b0;
                // R9: scramble operands after acceptance
                dest = ~4'(dst); cur_base = AW'(cb + 333); ref_base = AW'(rb + 77);
                stride = AW'(st + 5); ref_sel = ~hs;
            end
            if (inj != 0 && k == inj)     start = 1'b1;
            if (inj != 0 && k == inj + 1) start = 1'b0;
            if (cur_rd_en) cur_n++;
            if (hs ? half_rd_en : full_rd_en) sel_n++;
            if (hs ? full_rd_en : half_rd_en) oth_n++;
            if (k >= 1 && k <= 4) begin
                chk(cur_rd_addr == AW'(cb + k - 1), "R3 cur addr", int'(cur_rd_addr), (cb + k - 1) % M);
                chk(ref_rd_addr == AW'(rb + (k - 1) * st), "R4 ref addr", int'(ref_rd_addr), (rb + (k - 1) * st) % M);
            end
            if (k <= 9) chk(busy == 1'b1, "R7 busy high", int'(busy), 1);
            if (k == 10) chk(busy == 1'b0, "R7 busy low", int'(busy), 0);
            if (done) begin
                done_n++;
                if (done_k == 0) begin
                    done_k = k; wd = int'(gpr_wdata); wa = int'(gpr_waddr);
                    chk(gpr_we == 1'b1, "R2 gpr_we with done", int'(gpr_we), 1);
                end
            end
            if (done_n == 1 && k == 9 && inj == 0) break;
        end
        chk(done_k == 9, "R2 latency", done_k, 9);
        if (inj != 0) chk(done_n == 1, "R7 single done", done_n, 1);
        chk(wd == expv, "R1 sad value", wd, expv);
        chk(wa == dst, "R6 dest index", wa, dst);
        chk(cur_n == 4, "R3 cur reads", cur_n, 4);
        chk(sel_n == 4, "R4 ref reads", sel_n, 4);
        chk(oth_n == 0, "R5 other memory idle", oth_n, 0);
        start = 1'b0; ref_sel = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < M; a++) begin
            cur_mem[a]  = 8'((a * 37 + 11) & 255);
            full_mem[a] = 8'(((a * 73) ^ 90) & 255);
            half_mem[a] = 8'((a * 29 + 200) & 255);
        end
        // R1 extremes: all-max against all-zero, and equal pixels
        for (int i = 0; i < 4; i++) begin
            cur_mem[500 + i]  = 8'd255;
            full_mem[600 + i] = 8'd0;
            cur_mem[700 + i]  = 8'(i * 50);
            half_mem[800 + 2 * i] = 8'(i * 50);
        end

        repeat (3) @(negedge clk);
        // R8 reset state
        chk(busy == 0 && done == 0 && gpr_we == 0, "R8 reset outputs", int'({busy, done, gpr_we}), 0);
        chk(cur_rd_en == 0 && full_rd_en == 0 && half_rd_en == 0, "R8 reset enables",
            int'({cur_rd_en, full_rd_en, half_rd_en}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0, "R8 after reset", int'({busy, done}), 0);

        // R1 extremes
        run_op(500, 600, 1, 1'b0, 3, 0);
        chk(exp_sad(500, 600, 1, 1'b0) == 1020, "R1 max is 1020", exp_sad(500, 600, 1, 1'b0), 1020);
        run_op(700, 800, 2, 1'b1, 12, 0);

        // R1 R4 R5 sweep over memories, strides and bases
        begin
            int n = 0;
            for (int hs = 0; hs < 2; hs++)
                for (int si = 0; si < 5; si++)
                    for (int bi = 0; bi < 3; bi++) begin
                        int st = (si == 0) ? 1 : (si == 1) ? 2 : (si == 2) ? 3 : (si == 3) ? 5 : 16;
                        run_op(bi * 97 + si, bi * 211 + 40, st, hs[0], n % 16, 0);
                        n++;
                    end
        end

        // R3 R4 address wrap at the top of the space
        run_op(1022, 1020, 3, 1'b0, 9, 0);
        run_op(1021, 1019, 2, 1'b1, 15, 0);

        // R7 competing start during fetch and in the done cycle
        run_op(123, 456, 2, 1'b0, 5, 2);
        run_op(321, 654, 1, 1'b1, 6, 9);
        // start in the cycle right after done is accepted
        run_op(10, 20, 4, 1'b0, 0, 0);
        run_op(30, 40, 2, 1'b1, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule